// File: doc/BRIEF.md
# I2C Master Serial Clock Generator

This block produces the serial clock of an I2C bus master from a much faster system clock. A prescaler first turns the system clock into a slower count tick. Two phase dividers then set how many ticks the line is held low and how many ticks it is left released (high). The output is a single pull-down enable for an open-drain pad: asserted means "drive SCL low", deasserted means "let the pull-up raise it".

Because SCL is a wired-AND line, the generator watches the synchronized line level. It does not start counting high time until the line really reads high, so slaves that stretch the clock and slower masters are honoured. It abandons its high phase at once when another master pulls the line low. A hold request from the byte engine parks the clock low between bytes. Three one-cycle strobes tell a data engine where the edges are: own release (rising), own pull (falling) and the middle of each high phase (data sample point).

The configuration (prescale and the two divider values) is captured only while the block is disabled. Rewriting the inputs while it runs has no effect.

Top module: `i2c_sclgen`

## Requirements
- R1: A prescaler tick occurs every (prescale + 1) system cycles, counted from the start of each phase. Every phase length below is a tick count multiplied by (prescale + 1) cycles. With prescale above 0, two ticks are never adjacent.
- R2: Each low phase holds `scl_pull` at 1 for exactly (low_div + d) × (prescale + 1) cycles, unless the hold request extends it.
- R3: Each high phase lasts (high_div + d) × (prescale + 1) cycles. It is measured from the first cycle after the cycle in which the released line first reads high. `scl_pull` then returns to 1 at the end of the phase.
- R4: The divider offset d is 7 for prescale 0, 6 for prescale 1, and 5 for any prescale of 2 or more.
- R5: `prescale`, `low_div` and `high_div` are captured on every cycle while `enable` is 0 and are frozen while `enable` is 1. Changing them while enabled leaves the clock timing unchanged.
- R6: If the line reads low while the generator is in its high phase, `scl_pull` is 1 on the next cycle and a complete fresh low phase follows.
- R7: After its own low phase ends, the generator keeps the line released without counting high time for as long as another device holds the line low.
- R8: While `hold` is 1, a low phase that has reached its count does not end: `scl_pull` stays 1 and no rising strobe is produced. The release happens on the first tick on which `hold` is sampled 0.
- R9: `scl_rise_stb` is 1 for one cycle in the first released cycle after a low phase. `scl_fall_stb` is 1 for one cycle in the first cycle of each low phase. At most one strobe is active in any cycle.
- R10: `scl_mid_stb` is 1 for one cycle, (floor((high_div + d)/2) × (prescale + 1)) cycles after the first high cycle. It is not produced for a high phase that another master cuts short before that point.
- R11: While `enable` or `master` is 0, `scl_pull` is 0 from the next cycle on, no strobes occur and all counters are cleared. After reset the same holds. On activation with the line high, the first high cycle is the cycle after the activating one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; configuration is captured while 0 |
| master | input | 1 | Block is acting as bus master |
| prescale | input | PSC_W | Prescaler setting, divides by prescale + 1 |
| low_div | input | DIV_W | Low phase divider value |
| high_div | input | DIV_W | High phase divider value |
| hold | input | 1 | Byte engine request to park SCL low |
| scl_in | input | 1 | Synchronized level of the SCL line |
| scl_pull | output | 1 | 1 = pull SCL low, 0 = release |
| scl_rise_stb | output | 1 | One-cycle strobe on own release of SCL |
| scl_fall_stb | output | 1 | One-cycle strobe on own pull of SCL |
| scl_mid_stb | output | 1 | One-cycle strobe at the middle of the high phase |

## Verification
The bench closes the wired-AND loop itself: `scl_in` is low whenever the block or the bench's other-device pull drives it. The line is therefore high in the same cycle the block releases it, and the first high cycle is one cycle after each release. The bench computes each strobe's due cycle from the phase lengths: the mid strobe comes half a high phase after the first high cycle, the fall strobe a full high phase after it, and the rise strobe a low length after the fall. A hold release is seen one cycle after the tick, and the response to an outside pull is seen one cycle after the line drops. These due cycles are queued before the stimulus starts. The monitor compares each observed strobe with the head of the queue at the falling clock edge. At the end of each window the queue must be empty, so late, early, missing and extra edges all show up.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // Fixed extra ticks added to each divider, chosen by the prescale value.
  function automatic int unsigned div_offset(input int unsigned psc);
    if (psc == 0)      return 7;
    else if (psc == 1) return 6;
    else               return 5;
  endfunction

  // Number of prescaler ticks in one phase.
  function automatic int unsigned phase_len(input int unsigned div, input int unsigned psc);
    return div + div_offset(psc);
  endfunction

  // Tick count at which the high-phase sample point is placed.
  function automatic int unsigned half_point(input int unsigned len);
    return len >> 1;
  endfunction

endpackage

// File: rtl/sclgen_cfg.sv
module sclgen_cfg
  import sclgen_pkg::*;
#(
  parameter int PSC_W = 8,
  parameter int DIV_W = 8,
  parameter int LEN_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PSC_W-1:0] prescale,
  input  logic [DIV_W-1:0] low_div,
  input  logic [DIV_W-1:0] high_div,
  output logic [PSC_W-1:0] psc_q,
  output logic [LEN_W-1:0] low_len_q,
  output logic [LEN_W-1:0] high_len_q,
  output logic [LEN_W-1:0] high_half_q
);

  // Settings are sampled continuously while disabled and frozen otherwise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q       <= '0;
      low_len_q   <= '0;
      high_len_q  <= '0;
      high_half_q <= '0;
    end else if (load) begin
      psc_q       <= prescale;
      low_len_q   <= LEN_W'(phase_len(32'(low_div), 32'(prescale)));
      high_len_q  <= LEN_W'(phase_len(32'(high_div), 32'(prescale)));
      high_half_q <= LEN_W'(half_point(phase_len(32'(high_div), 32'(prescale))));
    end
  end

endmodule

// File: rtl/sclgen_tick.sv
module sclgen_tick #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);

  logic [PSC_W-1:0] cnt;

  assign tick = run && (cnt == psc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (!run || restart || tick) cnt <= '0;
    else                             cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/sclgen_phase.sv
module sclgen_phase
  import sclgen_pkg::*;
#(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             tick,
  input  logic             hold,
  input  logic             scl_in,
  input  logic [LEN_W-1:0] low_len,
  input  logic [LEN_W-1:0] high_len,
  input  logic [LEN_W-1:0] high_half,
  output logic             scl_pull,
  output logic             rise_stb,
  output logic             fall_stb,
  output logic             mid_stb,
  output logic             phase_chg,
  output logic             sync_drop
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  phase_e           ph, ph_nx;
  logic [LEN_W-1:0] pc, pc_nx;
  logic             low_term, high_term, mid_here;
  logic             low_done, high_done, go_high, mid_hit, count_en;

  assign low_term  = (pc == low_len - ONE);
  assign high_term = (pc == high_len - ONE);
  assign mid_here  = (pc == high_half - ONE);

  // Phase events
  assign low_done  = active && (ph == PH_LOW) && tick && low_term && !hold;
  assign high_done = active && (ph == PH_HIGH) && scl_in && tick && high_term;
  assign sync_drop = active && (ph == PH_HIGH) && !scl_in;
  assign go_high   = active && (ph == PH_WAIT) && scl_in;
  assign mid_hit   = active && (ph == PH_HIGH) && scl_in && tick && mid_here;

  always_comb begin
    ph_nx = ph;
    if (!active)                     ph_nx = PH_WAIT;
    else if (low_done)               ph_nx = PH_WAIT;
    else if (sync_drop || high_done) ph_nx = PH_LOW;
    else if (go_high)                ph_nx = PH_HIGH;
  end

  assign phase_chg = (ph_nx != ph);
  assign count_en  = tick && (((ph == PH_LOW) && !low_term) ||
                              ((ph == PH_HIGH) && !high_term));

  always_comb begin
    if (!active || phase_chg) pc_nx = '0;
    else if (count_en)        pc_nx = pc + ONE;
    else                      pc_nx = pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_WAIT;
      pc       <= '0;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
      mid_stb  <= 1'b0;
    end else begin
      ph       <= ph_nx;
      pc       <= pc_nx;
      rise_stb <= low_done;
      fall_stb <= sync_drop || high_done;
      mid_stb  <= mid_hit;
    end
  end

  assign scl_pull = (ph == PH_LOW);

endmodule

// File: rtl/i2c_sclgen.sv
module i2c_sclgen #(
  parameter int PSC_W = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             master,
  input  logic [PSC_W-1:0] prescale,
  input  logic [DIV_W-1:0] low_div,
  input  logic [DIV_W-1:0] high_div,
  input  logic             hold,
  input  logic             scl_in,
  output logic             scl_pull,
  output logic             scl_rise_stb,
  output logic             scl_fall_stb,
  output logic             scl_mid_stb
);

  localparam int LEN_W = DIV_W + 1;

  logic             active;
  logic             tick;
  logic             phase_chg;
  logic             sync_drop;
  logic [PSC_W-1:0] psc_q;
  logic [LEN_W-1:0] low_len_q, high_len_q, high_half_q;

  assign active = enable && master;

  sclgen_cfg #(.PSC_W(PSC_W), .DIV_W(DIV_W), .LEN_W(LEN_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (!enable),
    .prescale   (prescale),
    .low_div    (low_div),
    .high_div   (high_div),
    .psc_q      (psc_q),
    .low_len_q  (low_len_q),
    .high_len_q (high_len_q),
    .high_half_q(high_half_q)
  );

  sclgen_tick #(.PSC_W(PSC_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (active),
    .restart(phase_chg),
    .psc    (psc_q),
    .tick   (tick)
  );

  sclgen_phase #(.LEN_W(LEN_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .tick     (tick),
    .hold     (hold),
    .scl_in   (scl_in),
    .low_len  (low_len_q),
    .high_len (high_len_q),
    .high_half(high_half_q),
    .scl_pull (scl_pull),
    .rise_stb (scl_rise_stb),
    .fall_stb (scl_fall_stb),
    .mid_stb  (scl_mid_stb),
    .phase_chg(phase_chg),
    .sync_drop(sync_drop)
  );

endmodule

// File: rtl/sclgen_checker.sv
module sclgen_checker #(
  parameter int PSC_W = 8,
  parameter int CFG_W = 26
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             active,
  input logic             tick,
  input logic [PSC_W-1:0] psc_q,
  input logic [CFG_W-1:0] cfg_bus,
  input logic             hold,
  input logic             scl_in,
  input logic             sync_drop,
  input logic             scl_pull,
  input logic             rise,
  input logic             fall,
  input logic             mid
);

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    active && (psc_q != '0) && tick |=> !tick); // R1

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable(cfg_bus)); // R5

  AST_SYNC_PULLS: assert property (@(posedge clk) disable iff (!rst_n)
    sync_drop |=> scl_pull && fall); // R6

  AST_WAIT_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    active && !scl_pull && !scl_in |=> !mid); // R7

  AST_HOLD_PARKS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    active && scl_pull && hold |=> scl_pull && !rise); // R8

  AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> !scl_pull && $past(scl_pull)); // R9

  AST_FALL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> scl_pull && !$past(scl_pull)); // R9

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall, mid})); // R9

  AST_MID_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    mid |-> !scl_pull); // R10

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !scl_pull && !rise && !fall && !mid); // R11

endmodule

bind i2c_sclgen sclgen_checker #(
  .PSC_W(PSC_W),
  .CFG_W(PSC_W + 2 * (DIV_W + 1))
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .active   (active),
  .tick     (tick),
  .psc_q    (psc_q),
  .cfg_bus  ({psc_q, low_len_q, high_len_q}),
  .hold     (hold),
  .scl_in   (scl_in),
  .sync_drop(sync_drop),
  .scl_pull (scl_pull),
  .rise     (scl_rise_stb),
  .fall     (scl_fall_stb),
  .mid      (scl_mid_stb)
);

// File: tb/sim_i2c_sclgen.sv
module sim_i2c_sclgen;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       master = 1'b0;
  logic [7:0] prescale = '0;
  logic [7:0] low_div = '0;
  logic [7:0] high_div = '0;
  logic       hold = 1'b0;
  logic       ext_pull = 1'b0;
  logic       scl_in;
  logic       scl_pull, scl_rise_stb, scl_fall_stb, scl_mid_stb;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Scoreboard: kind 0 = rise, 1 = fall, 2 = mid
  int    q_kind[$];
  int    q_cyc[$];
  string q_tag[$];

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Wired-AND line: low when either side pulls
  assign scl_in = ~(scl_pull | ext_pull);

  i2c_sclgen u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .master      (master),
    .prescale    (prescale),
    .low_div     (low_div),
    .high_div    (high_div),
    .hold        (hold),
    .scl_in      (scl_in),
    .scl_pull    (scl_pull),
    .scl_rise_stb(scl_rise_stb),
    .scl_fall_stb(scl_fall_stb),
    .scl_mid_stb (scl_mid_stb)
  );

  task automatic push(input int kind, input int at, input string tag);
    q_kind.push_back(kind);
    q_cyc.push_back(at);
    q_tag.push_back(tag);
  endtask

  task automatic sb_pop(input int kind);
    int k, c;
    string t;
    checks++;
    if (q_kind.size() == 0) begin
      failures++;
      $display("FAIL R9 unexpected strobe kind=%0d at cycle %0d, expected none", kind, cyc);
    end else begin
      k = q_kind.pop_front();
      c = q_cyc.pop_front();
      t = q_tag.pop_front();
      if (k != kind || c != cyc) begin
        failures++;
        $display("FAIL %s strobe kind=%0d cycle=%0d, expected kind=%0d cycle=%0d", t, kind, cyc, k, c);
      end
    end
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (scl_rise_stb) sb_pop(0);
      if (scl_fall_stb) sb_pop(1);
      if (scl_mid_stb)  sb_pop(2);
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", tag, cyc, act, exp);
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  function automatic int offs(input int p);
    int m;
    m = (p > 2) ? 2 : p;
    return 7 - m;
  endfunction

  task automatic setup(input int p, input int lo, input int hi, output int h0);
    @(negedge clk);
    enable = 1'b0;
    master = 1'b0;
    prescale = 8'(p);
    low_div = 8'(lo);
    high_div = 8'(hi);
    repeat (2) @(negedge clk);
    enable = 1'b1;
    master = 1'b1;
    h0 = cyc + 1;
  endtask

  task automatic push_sched(input int h0, input int p, input int lo, input int hi,
                            input int periods, input string tag, output int w);
    int hc, lc, hf, per, base;
    hc  = (hi + offs(p)) * (p + 1);
    lc  = (lo + offs(p)) * (p + 1);
    hf  = ((hi + offs(p)) / 2) * (p + 1);
    per = hc + lc + 1;
    for (int k = 0; k < periods; k++) begin
      base = h0 + k * per;
      push(2, base + hf, (tag == "") ? "R10" : tag);
      push(1, base + hc, (tag == "") ? "R3" : tag);
      push(0, base + hc + lc, (tag == "") ? "R2" : tag);
    end
    w = h0 + periods * per - 1;
  endtask

  task automatic finish_win(input int w, input string tag);
    wait_until(w);
    enable = 1'b0;
    master = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (q_kind.size() != 0) begin
      failures++;
      $display("FAIL %s missing strobes: actual pending=%0d expected 0", tag, q_kind.size());
    end
    q_kind.delete();
    q_cyc.delete();
    q_tag.delete();
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int h0, w, f, r, e, s, b, h1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk(scl_pull, 1'b0, "R11 reset pull");
    chk(scl_rise_stb | scl_fall_stb | scl_mid_stb, 1'b0, "R11 reset strobes");

    // Basic timing, prescale 0: d=7, low 10, high 9
    setup(0, 3, 2, h0);
    push_sched(h0, 0, 3, 2, 2, "", w);
    wait_until(h0 + 9);
    chk(scl_pull, 1'b1, "R9 pull at fall strobe");
    wait_until(h0 + 18);
    chk(scl_pull, 1'b1, "R2 last low cycle");
    wait_until(h0 + 19);
    chk(scl_pull, 1'b0, "R2 released after low");
    finish_win(w, "R2");

    // R1/R4: prescale 1, d=6
    setup(1, 4, 6, h0);
    push_sched(h0, 1, 4, 6, 2, "R1", w);
    finish_win(w, "R1");

    // R4: prescale 3, d=5
    setup(3, 0, 1, h0);
    push_sched(h0, 3, 0, 1, 2, "R4", w);
    finish_win(w, "R4");

    // R5: changes while enabled are ignored
    setup(0, 3, 2, h0);
    push_sched(h0, 0, 3, 2, 2, "R5", w);
    wait_until(h0 + 3);
    prescale = 8'd5;
    low_div = 8'd40;
    high_div = 8'd40;
    finish_win(w, "R5");

    // R7: line stretched by another device after own release
    setup(0, 3, 2, h0);
    f = h0 + 9;
    r = f + 10;
    e = r + 7;
    push(2, h0 + 4, "R10");
    push(1, f, "R3");
    push(0, r, "R2");
    push(2, e + 5, "R7");
    push(1, e + 10, "R7");
    push(0, e + 20, "R7");
    wait_until(f + 2);
    ext_pull = 1'b1;
    wait_until(r + 3);
    chk(scl_pull, 1'b0, "R7 released while stretched");
    wait_until(e);
    ext_pull = 1'b0;
    finish_win(e + 20, "R7");

    // R6: another master pulls during our high phase
    setup(0, 3, 2, h0);
    s = h0 + 2;
    push(1, s + 1, "R6");
    push(0, s + 11, "R6");
    push(2, s + 16, "R6");
    push(1, s + 21, "R6");
    push(0, s + 31, "R6");
    wait_until(s);
    ext_pull = 1'b1;
    wait_until(s + 1);
    chk(scl_pull, 1'b1, "R6 pull after drop");
    wait_until(s + 3);
    ext_pull = 1'b0;
    finish_win(s + 31, "R6");

    // R8: hold parks the clock low
    setup(0, 3, 2, h0);
    f = h0 + 9;
    b = f + 20;
    push(2, h0 + 4, "R10");
    push(1, f, "R3");
    push(0, b + 1, "R8");
    push(2, b + 6, "R8");
    push(1, b + 11, "R8");
    push(0, b + 21, "R8");
    wait_until(f + 1);
    hold = 1'b1;
    wait_until(f + 15);
    chk(scl_pull, 1'b1, "R8 low while held");
    wait_until(b);
    hold = 1'b0;
    finish_win(b + 21, "R8");

    // R11: leaving master role releases and clears counters
    setup(0, 3, 2, h0);
    push(2, h0 + 4, "R10");
    push(1, h0 + 9, "R3");
    wait_until(h0 + 12);
    master = 1'b0;
    wait_until(h0 + 13);
    chk(scl_pull, 1'b0, "R11 released when not master");
    wait_until(h0 + 16);
    master = 1'b1;
    h1 = h0 + 17;
    push_sched(h1, 0, 3, 2, 1, "R11", w);
    finish_win(w, "R11");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule